// File: doc/BRIEF.md
# Sparse Selector Integrity Guard

This block sits between a sequencing controller and the datapath it steers. The controller does not drive plain binary selects. It drives each multiplexer select and each register write enable as a multi-bit sparse codeword. Every codeword first passes through its own buffer boundary, so the encoding survives as a separate net. A legality checker then compares it against the small set of allowed values. Any value outside that set counts as a fault.

The fault indications from all checkers are ORed together. The result is captured in a sticky register that only reset can clear. In the same cycle that an illegal value appears, the downstream output-valid handshake is forced low. From the next cycle on, the alert output stays high. Because the fault is registered, the controller can observe the alert without forming a combinational loop through its own valid logic.

A guarded multiplexer that receives an illegal select does not pass any of its data sources. It drives the caller-supplied pseudo-random clearing word instead, so secret data can never leak through a corrupted select.

Top module: `sel_guard`

## Requirements
- R1: Each mux select is 6 bits wide. Codeword 6'b001011 routes source 0, 6'b010101 routes source 1, 6'b100110 routes source 2, and 6'b111000 routes the clearing word. Mux s reads source k from `src_i[(s*3+k)*16 +: 16]` and its clearing word from `clr_i[s*16 +: 16]`.
- R2: Any other 6-bit select value drives that mux's clearing word on `mux_o[s*16 +: 16]`, never a source.
- R3: Each write enable is 3 bits wide in `we_i[i*3 +: 3]`. `we_o[i]` is 1 only for the code 3'b011. It is 0 for 3'b100 and for every other value.
- R4: An enable value other than 3'b011 or 3'b100 counts as a fault.
- R5: A select value outside the four codewords of R1 counts as a fault.
- R6: `alert_o` is 0 after reset. It is 1 in the cycle after the first cycle in which any fault is present.
- R7: Once `alert_o` is 1, it stays 1 until reset, even after every input returns to a legal codeword.
- R8: `out_valid_o` equals `out_valid_i` while no fault is present and `alert_o` is 0. It is 0 in the very cycle a fault appears and in every cycle after that.
- R9: Asserting `rst_ni` low clears the alert. After reset, `out_valid_o` follows `out_valid_i` again.
- R10: The legal codewords are at least Hamming distance 3 apart, so flipping any single bit of any legal select or enable code is detected as a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 12 | Sparse selects, 6 bits per mux, mux 0 in the low bits |
| src_i | input | 96 | Three 16-bit sources per mux |
| clr_i | input | 32 | 16-bit pseudo-random clearing word per mux |
| we_i | input | 9 | Sparse write enables, 3 bits each |
| out_valid_i | input | 1 | Output-valid from the controller |
| mux_o | output | 32 | Guarded mux results |
| we_o | output | 3 | Single-rail write enables |
| out_valid_o | output | 1 | Gated output-valid |
| alert_o | output | 1 | Sticky fault alert |

## Verification
The first pattern sweeps every legal select codeword on both muxes while the enables alternate between their two legal codes. This shows that routing and enable decoding are correct and that legal traffic never raises the alert. The second pattern flips each single bit of every legal select and enable code, each time starting from reset. This separates a decoder that tolerates near-miss codes from one that flags them, and it checks the same-cycle valid gating. The third pattern returns to legal codes after a fault, which separates a sticky alert from a level that merely follows the input. A final all-zero select checks that the clearing word is chosen for a value far from any codeword.

// File: rtl/sel_guard_pkg.sv
package sel_guard_pkg;
  localparam int SEL_W     = 6;
  localparam int EN_W      = 3;
  localparam int NUM_CODES = 4;
  localparam int NUM_SRC   = NUM_CODES - 1;

  // index k at bits k*SEL_W; last index selects the clearing word
  localparam logic [NUM_CODES*SEL_W-1:0] SEL_CODES =
    {6'b111000, 6'b100110, 6'b010101, 6'b001011};

  localparam logic [EN_W-1:0] EN_OFF = 3'b100;
  localparam logic [EN_W-1:0] EN_ON  = 3'b011;
  localparam logic [2*EN_W-1:0] EN_CODES = {EN_ON, EN_OFF};
endpackage

// File: rtl/sg_keep_buf.sv
module sg_keep_buf #(
  parameter int W = 4
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  // separate boundary so the sparse code reaches the checker intact
  assign out_o = in_i;
endmodule

// File: rtl/sg_code_chk.sv
module sg_code_chk #(
  parameter int W   = 6,
  parameter int NUM = 4,
  parameter logic [NUM*W-1:0] CODES = '0
) (
  input  logic [W-1:0]   code_i,
  output logic [NUM-1:0] hit_o,
  output logic           err_o
);
  for (genvar k = 0; k < NUM; k++) begin : g_hit
    assign hit_o[k] = (code_i == CODES[k*W +: W]);
  end
  assign err_o = ~|hit_o;
endmodule

// File: rtl/sg_guard_mux.sv
module sg_guard_mux #(
  parameter int DATA_W  = 16,
  parameter int NUM_SRC = 3
) (
  input  logic [NUM_SRC:0]          hit_i,
  input  logic [NUM_SRC*DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0]         clr_i,
  output logic [DATA_W-1:0]         out_o
);
  // clear code or no hit at all falls through to the clearing word
  always_comb begin
    out_o = clr_i;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (hit_i[k]) out_o = src_i[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/sg_fault_latch.sv
module sg_fault_latch #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] err_i,
  output logic         err_now_o,
  output logic         fault_o
);
  assign err_now_o = |err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fault_o <= 1'b0;
    else if (err_now_o) fault_o <= 1'b1;
  end
endmodule

// File: rtl/sel_guard.sv
module sel_guard
  import sel_guard_pkg::*;
#(
  parameter int NUM_SEL = 2,
  parameter int NUM_WE  = 3,
  parameter int DATA_W  = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_SEL*SEL_W-1:0]          sel_i,
  input  logic [NUM_SEL*NUM_SRC*DATA_W-1:0] src_i,
  input  logic [NUM_SEL*DATA_W-1:0]         clr_i,
  input  logic [NUM_WE*EN_W-1:0]            we_i,
  input  logic                              out_valid_i,
  output logic [NUM_SEL*DATA_W-1:0]         mux_o,
  output logic [NUM_WE-1:0]                 we_o,
  output logic                              out_valid_o,
  output logic                              alert_o
);
  localparam int NUM_ERR = NUM_SEL + NUM_WE;

  logic [NUM_ERR-1:0] err_vec;
  logic               err_now;
  logic               fault_q;

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    logic [SEL_W-1:0]     sel_buf;
    logic [NUM_CODES-1:0] hit;

    sg_keep_buf #(.W(SEL_W)) u_buf (
      .in_i (sel_i[s*SEL_W +: SEL_W]),
      .out_o(sel_buf)
    );
    sg_code_chk #(.W(SEL_W), .NUM(NUM_CODES), .CODES(SEL_CODES)) u_chk (
      .code_i(sel_buf),
      .hit_o (hit),
      .err_o (err_vec[s])
    );
    sg_guard_mux #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_mux (
      .hit_i(hit),
      .src_i(src_i[s*NUM_SRC*DATA_W +: NUM_SRC*DATA_W]),
      .clr_i(clr_i[s*DATA_W +: DATA_W]),
      .out_o(mux_o[s*DATA_W +: DATA_W])
    );
  end

  for (genvar i = 0; i < NUM_WE; i++) begin : g_we
    logic [EN_W-1:0] we_buf;
    logic [1:0]      hit;

    sg_keep_buf #(.W(EN_W)) u_buf (
      .in_i (we_i[i*EN_W +: EN_W]),
      .out_o(we_buf)
    );
    sg_code_chk #(.W(EN_W), .NUM(2), .CODES(EN_CODES)) u_chk (
      .code_i(we_buf),
      .hit_o (hit),
      .err_o (err_vec[NUM_SEL+i])
    );
    assign we_o[i] = hit[1] & ~hit[0];
  end

  sg_fault_latch #(.N(NUM_ERR)) u_fault (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .err_i    (err_vec),
    .err_now_o(err_now),
    .fault_o  (fault_q)
  );

  // same-cycle block on a live error, sticky block after
  assign out_valid_o = out_valid_i & ~err_now & ~fault_q;
  assign alert_o     = fault_q;
endmodule

// File: rtl/sel_guard_sva.sv
module sel_guard_sva
  import sel_guard_pkg::*;
#(
  parameter int NUM_SEL = 2,
  parameter int NUM_WE  = 3,
  parameter int DATA_W  = 16
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [NUM_SEL*SEL_W-1:0]          sel_i,
  input logic [NUM_SEL*NUM_SRC*DATA_W-1:0] src_i,
  input logic [NUM_SEL*DATA_W-1:0]         clr_i,
  input logic [NUM_WE*EN_W-1:0]            we_i,
  input logic                              out_valid_i,
  input logic [NUM_SEL*DATA_W-1:0]         mux_o,
  input logic [NUM_WE-1:0]                 we_o,
  input logic                              out_valid_o,
  input logic                              alert_o
);
  logic any_bad;
  always_comb begin
    any_bad = 1'b0;
    for (int s = 0; s < NUM_SEL; s++) begin
      logic ok;
      ok = 1'b0;
      for (int k = 0; k < NUM_CODES; k++)
        if (sel_i[s*SEL_W +: SEL_W] == SEL_CODES[k*SEL_W +: SEL_W]) ok = 1'b1;
      if (!ok) any_bad = 1'b1;
    end
    for (int i = 0; i < NUM_WE; i++)
      if (we_i[i*EN_W +: EN_W] != EN_ON && we_i[i*EN_W +: EN_W] != EN_OFF) any_bad = 1'b1;
  end

  assert_fault_raises_alert_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_bad |=> alert_o);

  assert_alert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |=> alert_o);

  assert_valid_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_bad || alert_o) |-> !out_valid_o);

  assert_valid_passes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_bad && !alert_o) |-> (out_valid_o == out_valid_i));

  for (genvar i = 0; i < NUM_WE; i++) begin : g_we_sva
    assert_we_only_on_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_o[i] |-> (we_i[i*EN_W +: EN_W] == EN_ON));
  end

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel_sva
    logic legal;
    always_comb begin
      legal = 1'b0;
      for (int k = 0; k < NUM_CODES; k++)
        if (sel_i[s*SEL_W +: SEL_W] == SEL_CODES[k*SEL_W +: SEL_W]) legal = 1'b1;
    end
    assert_illegal_sel_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !legal |-> (mux_o[s*DATA_W +: DATA_W] == clr_i[s*DATA_W +: DATA_W]));
  end
endmodule

bind sel_guard sel_guard_sva #(.NUM_SEL(NUM_SEL), .NUM_WE(NUM_WE), .DATA_W(DATA_W)) u_sva (.*);

// File: tb/sel_guard_bench.sv
module sel_guard_bench;
  localparam int NS = 2, NW = 3, DW = 16;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic [NS*6-1:0] sel_i;
  logic [NS*3*DW-1:0] src_i;
  logic [NS*DW-1:0]   clr_i;
  logic [NW*3-1:0]    we_i;
  logic               out_valid_i;
  logic [NS*DW-1:0]   mux_o;
  logic [NW-1:0]      we_o;
  logic               out_valid_o;
  logic               alert_o;

  int total = 0;
  int bad   = 0;
  bit exp_fault = 0;

  // codewords from R1 and R3
  logic [5:0] codes [4] = '{6'b001011, 6'b010101, 6'b100110, 6'b111000};
  localparam logic [2:0] ON = 3'b011, OFF = 3'b100;

  always #5 clk_i = ~clk_i;

  sel_guard u_sel_guard (.*);

  function automatic int sel_idx(logic [5:0] c);
    for (int k = 0; k < 4; k++) if (c == codes[k]) return k;
    return -1;
  endfunction

  function automatic bit any_illegal();
    for (int s = 0; s < NS; s++) if (sel_idx(sel_i[s*6 +: 6]) < 0) return 1;
    for (int i = 0; i < NW; i++)
      if (we_i[i*3 +: 3] != ON && we_i[i*3 +: 3] != OFF) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit ill;
    ill = any_illegal();
    for (int s = 0; s < NS; s++) begin
      int k;
      logic [DW-1:0] e;
      k = sel_idx(sel_i[s*6 +: 6]);
      e = (k >= 0 && k < 3) ? src_i[(s*3+k)*DW +: DW] : clr_i[s*DW +: DW];
      chk(k < 0 ? "R2 mux clear on illegal" : "R1 mux route", 64'(mux_o[s*DW +: DW]), 64'(e));
    end
    for (int i = 0; i < NW; i++)
      chk("R3 enable decode", 64'(we_o[i]), 64'(we_i[i*3 +: 3] == ON));
    chk("R8 out_valid gating", 64'(out_valid_o), 64'(out_valid_i && !exp_fault && !ill));
    chk("R6 R7 alert level", 64'(alert_o), 64'(exp_fault));
  endtask

  task automatic tick();
    #4;
    compare();
    @(posedge clk_i);
    if (any_illegal()) exp_fault = 1;
    @(negedge clk_i);
  endtask

  task automatic legal_inputs(int n);
    for (int s = 0; s < NS; s++) sel_i[s*6 +: 6] = codes[(n + s) % 4];
    for (int i = 0; i < NW; i++) we_i[i*3 +: 3] = ((n + i) % 2) ? ON : OFF;
    src_i       = {6{16'(n * 37 + 16'h1a5)}} ^ 96'h0123_4567_89ab_cdef_f0e1_d2c3;
    clr_i       = {2{16'(n * 91 + 16'h5c3)}} ^ 32'h9e37_79b9;
    out_valid_i = (n % 3) != 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    exp_fault = 0;
    #2;
    chk("R9 alert cleared in reset", 64'(alert_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    legal_inputs(0);
    @(negedge clk_i);
    #1;
    chk("R6 alert low in reset", 64'(alert_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // legal sweep
    for (int n = 0; n < 24; n++) begin
      legal_inputs(n);
      tick();
    end

    // fault then return to legal: sticky (R7), then reset recovery (R9)
    legal_inputs(5);
    sel_i[5:0] = codes[1] ^ 6'b000100;
    tick();
    for (int n = 0; n < 6; n++) begin
      legal_inputs(n);
      tick();
    end
    do_reset();
    legal_inputs(1);
    tick();
    chk("R9 valid follows after reset", 64'(out_valid_o), 64'(out_valid_i));

    // R10 single-bit flips on every select code (R5)
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 6; b++) begin
        do_reset();
        legal_inputs(k);
        out_valid_i = 1'b1;
        sel_i[6 +: 6] = codes[k] ^ (6'd1 << b);
        tick();
        legal_inputs(k);
        tick();
      end
    end

    // R10 single-bit flips on enable codes (R4)
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < 3; b++) begin
        do_reset();
        legal_inputs(c);
        out_valid_i = 1'b1;
        we_i[3 +: 3] = (c ? ON : OFF) ^ (3'd1 << b);
        tick();
        legal_inputs(c);
        tick();
      end
    end

    // all-zero select far from every codeword
    do_reset();
    legal_inputs(2);
    sel_i[5:0] = 6'b000000;
    tick();
    tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule